// File: doc/BRIEF.md
# PLL Lock Qualifier

This block sits beside a PLL and turns its raw lock flag, which can chatter while the loop first pulls in, into a clean qualified lock output. After every reset, a saturating counter on the reference clock keeps the qualified output low for a fixed number of reference cycles. That number is the worst-case lock time divided by the reference period: a 1 ms lock time at a 10 ns period gives 100,000 cycles and a 17-bit counter. The raw lock can toggle during that window without restarting the count. Once the window has elapsed, the output follows the raw lock after a two-flop synchroniser.

The PLL reset output repeats the external reset request, so the PLL and this qualifier start again together. An optional self-reset mode watches for lock loss after the qualified output has gone high. When that happens, it drives the PLL reset for a fixed pulse length, drops the qualified output and starts the hold window again. The external reset is taken in asynchronously and released through a synchroniser on the reference clock.

Top module: `lockq_top`

## Requirements
- R1: While `areset_req` is high, `pll_reset` is high and `gated_lock` is low in the same cycle, whatever `raw_lock` does.
- R2: After `areset_req` is released in cycle r, counted in rising edges of `clk_ref`, `gated_lock` stays low through cycle r+LOCK_CYCLES+1. If `raw_lock` is high, it rises in cycle r+LOCK_CYCLES+2.
- R3: Once the hold window has elapsed and with no self-reset pending, `gated_lock` in cycle n equals `raw_lock` in cycle n-2. A one-cycle dip of `raw_lock` appears as a one-cycle dip of `gated_lock`.
- R4: Toggling `raw_lock` during the hold window does not restart or lengthen the window. The rise time given in R2 still holds.
- R5: With SELF_RESET=1, if `raw_lock` falls in cycle a while `gated_lock` is high, then `gated_lock` is low from cycle a+2. `pll_reset` is high for exactly RESET_PULSE cycles, a+3 to a+2+RESET_PULSE, and low again in cycle a+3+RESET_PULSE.
- R6: After a self-reset pulse ends in cycle e, the hold window starts again: `gated_lock` stays low through cycle e+LOCK_CYCLES-1 and, with `raw_lock` high, rises in cycle e+LOCK_CYCLES.
- R7: With SELF_RESET=0, loss of lock never drives `pll_reset`, and `gated_lock` keeps following `raw_lock` as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | PLL reference clock; every register of the block runs on it |
| areset_req | input | 1 | Active-high reset request; asserted asynchronously, released through a synchroniser |
| raw_lock | input | 1 | Unqualified lock flag from the PLL; may glitch |
| gated_lock | output | 1 | Qualified lock flag |
| pll_reset | output | 1 | Reset drive to the PLL: the reset request combined with any self-reset pulse |

## Verification
`areset_req` acts on both outputs in the cycle it is driven. A release takes two edges to pass through the reset synchroniser, so the qualified lock is due LOCK_CYCLES+2 cycles after the release. A `raw_lock` change reaches `gated_lock` two cycles later. A lock loss starts the self-reset pulse three cycles later, and the next rise of `gated_lock` is due LOCK_CYCLES cycles after the pulse ends. The bench drives inputs just after a rising edge and samples on the falling edge. It computes each expected value for an exact cycle number taken from these latencies and queues it. The monitor compares only in that cycle, so both an early change and a late change are caught.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

    // Bits needed to hold values 0..n inclusive.
    function automatic int unsigned cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Control bundle shared between the qualifier stages.
    typedef struct packed {
        logic rst;   // synchronised internal reset
        logic lock;  // synchronised raw lock
        logic done;  // hold window elapsed
        logic fire;  // lock lost after qualification
    } lockq_ctl_t;

endpackage

// File: rtl/lockq_rst_sync.sv
module lockq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic rst_q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh <= '1;
        else      sh <= {sh[STAGES-2:0], 1'b0};
    end

    assign rst_q = sh[STAGES-1];
endmodule

// File: rtl/lockq_bit_sync.sv
module lockq_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (srst) sh <= '0;
        else      sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/lockq_hold_ctr.sv
module lockq_hold_ctr #(
    parameter int unsigned LOCK_CYCLES = 100000
) (
    input  logic clk,
    input  logic restart,
    output logic done
);
    localparam int W = lockq_pkg::cnt_bits(LOCK_CYCLES);
    localparam logic [W-1:0] TERM = W'(LOCK_CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (restart)          cnt <= '0;
        else if (cnt != TERM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == TERM);
endmodule

// File: rtl/lockq_kick.sv
module lockq_kick #(
    parameter int unsigned RESET_PULSE = 16
) (
    input  logic clk,
    input  logic srst,
    input  logic fire,
    output logic active
);
    localparam int KW = lockq_pkg::cnt_bits(RESET_PULSE);
    localparam logic [KW-1:0] KTERM = KW'(RESET_PULSE);

    logic [KW-1:0] left;

    always_ff @(posedge clk) begin
        if (srst)            left <= '0;
        else if (fire)       left <= KTERM;
        else if (left != '0) left <= left - 1'b1;
    end

    assign active = (left != '0);
endmodule

// File: rtl/lockq_top.sv
module lockq_top #(
    parameter int unsigned LOCK_CYCLES = 100000,
    parameter int unsigned RESET_PULSE = 16,
    parameter int          SYNC_STAGES = 2,
    parameter bit          SELF_RESET  = 1'b1
) (
    input  logic clk_ref,
    input  logic areset_req,
    input  logic raw_lock,
    output logic gated_lock,
    output logic pll_reset
);
    import lockq_pkg::*;

    logic       rst_s, lock_s, done, fire, kick_on, gl_q, restart;
    lockq_ctl_t ctl;

    lockq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(clk_ref), .arst(areset_req), .rst_q(rst_s)
    );

    lockq_bit_sync #(.STAGES(SYNC_STAGES)) u_lock (
        .clk(clk_ref), .srst(rst_s), .d(raw_lock), .q(lock_s)
    );

    // Counter is cleared by reset, by a new loss event and while the PLL is held in reset.
    assign restart = ctl.rst | ctl.fire | kick_on;

    lockq_hold_ctr #(.LOCK_CYCLES(LOCK_CYCLES)) u_hold (
        .clk(clk_ref), .restart(restart), .done(done)
    );

    assign ctl = '{rst: rst_s, lock: lock_s, done: done, fire: fire};

    // Qualified output; the async-set reset path masks it at once.
    assign gated_lock = ~ctl.rst & ctl.done & ctl.lock;

    always_ff @(posedge clk_ref) begin
        if (ctl.rst) gl_q <= 1'b0;
        else         gl_q <= gated_lock;
    end

    generate
        if (SELF_RESET) begin : g_self
            assign fire = gl_q & ~lock_s & ~rst_s;
            lockq_kick #(.RESET_PULSE(RESET_PULSE)) u_kick (
                .clk(clk_ref), .srst(ctl.rst), .fire(ctl.fire), .active(kick_on)
            );
        end else begin : g_plain
            assign fire    = 1'b0;
            assign kick_on = 1'b0;
        end
    endgenerate

    assign pll_reset = areset_req | kick_on;
endmodule

// File: rtl/lockq_chk.sv
module lockq_chk #(
    parameter int unsigned LOCK_CYCLES = 100000,
    parameter int unsigned RESET_PULSE = 16,
    parameter int          SYNC_STAGES = 2,
    parameter bit          SELF_RESET  = 1'b1
) (
    input logic clk_ref,
    input logic areset_req,
    input logic raw_lock,
    input logic gated_lock,
    input logic pll_reset
);
    logic kick;
    int   since;
    int   kc;

    assign kick = pll_reset & ~areset_req;

    // Cycles since the last reset request or self-reset pulse, saturating.
    always_ff @(posedge clk_ref or posedge areset_req) begin
        if (areset_req)                  since <= 0;
        else if (pll_reset)              since <= 0;
        else if (since <= LOCK_CYCLES+4) since <= since + 1;
    end

    // Length of the current self-reset pulse so far.
    always_ff @(posedge clk_ref or posedge areset_req) begin
        if (areset_req) kc <= 0;
        else if (kick)  kc <= kc + 1;
        else            kc <= 0;
    end

    p_reset_state_r1: assert property (@(posedge clk_ref)
        areset_req |-> (pll_reset && !gated_lock));

    // R2, R4 and R6: no qualified lock inside a hold window.
    p_hold_window_r2: assert property (@(posedge clk_ref) disable iff (areset_req)
        gated_lock |-> (since >= LOCK_CYCLES));

    generate
        if (SYNC_STAGES == 2) begin : g_follow
            p_follow_raw_r3: assert property (@(posedge clk_ref) disable iff (areset_req)
                gated_lock |-> $past(raw_lock, 2));
        end
    endgenerate

    p_pulse_short_r5: assert property (@(posedge clk_ref) disable iff (areset_req)
        kick |-> (kc < RESET_PULSE));

    p_pulse_full_r5: assert property (@(posedge clk_ref) disable iff (areset_req)
        $fell(kick) |-> (kc == RESET_PULSE));

    p_kick_drops_lock_r6: assert property (@(posedge clk_ref) disable iff (areset_req)
        kick |-> !gated_lock);

    generate
        if (!SELF_RESET) begin : g_nokick
            p_no_kick_r7: assert property (@(posedge clk_ref) disable iff (areset_req)
                !kick);
        end
    endgenerate
endmodule

bind lockq_top lockq_chk #(
    .LOCK_CYCLES(LOCK_CYCLES),
    .RESET_PULSE(RESET_PULSE),
    .SYNC_STAGES(SYNC_STAGES),
    .SELF_RESET(SELF_RESET)
) u_chk (
    .clk_ref(clk_ref),
    .areset_req(areset_req),
    .raw_lock(raw_lock),
    .gated_lock(gated_lock),
    .pll_reset(pll_reset)
);

// File: tb/tb_lockq_top.sv
module tb_lockq_top;
    localparam int L = 20;
    localparam int P = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic areset_req, raw_lock;
    logic gl_a, pr_a, gl_b, pr_b;

    lockq_top #(.LOCK_CYCLES(L), .RESET_PULSE(P), .SELF_RESET(1'b1)) dut (
        .clk_ref(clk), .areset_req(areset_req), .raw_lock(raw_lock),
        .gated_lock(gl_a), .pll_reset(pr_a)
    );

    lockq_top #(.LOCK_CYCLES(L), .RESET_PULSE(P), .SELF_RESET(1'b0)) dut_plain (
        .clk_ref(clk), .areset_req(areset_req), .raw_lock(raw_lock),
        .gated_lock(gl_b), .pll_reset(pr_b)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    function automatic logic probe(int s);
        case (s)
            0:       return gl_a;
            1:       return pr_a;
            2:       return gl_b;
            default: return pr_b;
        endcase
    endfunction

    function automatic string sname(int s);
        case (s)
            0:       return "gated_lock(self)";
            1:       return "pll_reset(self)";
            2:       return "gated_lock(plain)";
            default: return "pll_reset(plain)";
        endcase
    endfunction

    task automatic expect_at(int at, int sig, logic val, string req);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: on each falling edge, compare every item due in this cycle.
    initial begin
        forever begin
            @(negedge clk);
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    checks++;
                    if (probe(sb[i].sig) !== sb[i].val) begin
                        errors++;
                        $display("FAIL %s %s cycle %0d: actual %b expected %b",
                                 sb[i].req, sname(sb[i].sig), cyc,
                                 probe(sb[i].sig), sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_to(int n);
        while (cyc < n) tick();
    endtask

    int r, a, c, d;

    initial begin
        areset_req = 1'b1;
        raw_lock   = 1'b0;

        // R1: reset state of both instances
        expect_at(3, 0, 1'b0, "R1"); expect_at(3, 1, 1'b1, "R1");
        expect_at(3, 2, 1'b0, "R1"); expect_at(3, 3, 1'b1, "R1");

        // Phase A: release, glitching raw lock inside the hold window
        r = 8;
        for (int k = 1; k <= L + 1; k++) begin
            expect_at(r + k, 0, 1'b0, "R2");
            expect_at(r + k, 2, 1'b0, "R2");
        end
        expect_at(r + 1, 1, 1'b0, "R1");
        expect_at(r + L + 2, 0, 1'b1, "R4");
        expect_at(r + L + 2, 2, 1'b1, "R4");
        expect_at(r + L + 2, 1, 1'b0, "R2");

        wait_to(r);
        areset_req = 1'b0;
        for (int k = 1; k <= L - 4; k++) begin
            tick();
            raw_lock = k[0];
        end
        tick();
        raw_lock = 1'b1;

        // Phase B: one-cycle lock loss
        a = r + L + 10;
        expect_at(a + 1, 0, 1'b1, "R3");
        expect_at(a + 2, 0, 1'b0, "R5");
        expect_at(a + 2, 1, 1'b0, "R5");
        expect_at(a + 3, 1, 1'b1, "R5");
        expect_at(a + 2 + P, 1, 1'b1, "R5");
        expect_at(a + 3 + P, 1, 1'b0, "R5");
        expect_at(a + 3, 0, 1'b0, "R6");
        expect_at(a + 3 + P + L - 1, 0, 1'b0, "R6");
        expect_at(a + 3 + P + L, 0, 1'b1, "R6");
        expect_at(a + 1, 2, 1'b1, "R3");
        expect_at(a + 2, 2, 1'b0, "R3");
        expect_at(a + 3, 2, 1'b1, "R3");
        expect_at(a + 3, 3, 1'b0, "R7");
        expect_at(a + 4, 3, 1'b0, "R7");
        expect_at(a + 3 + P + L, 2, 1'b1, "R7");

        wait_to(a);
        raw_lock = 1'b0;
        tick();
        raw_lock = 1'b1;

        // Phase C: second reset request with raw lock held high
        c = a + 3 + P + L + 6;
        d = c + 4;
        expect_at(c, 0, 1'b0, "R1"); expect_at(c, 1, 1'b1, "R1");
        expect_at(c, 2, 1'b0, "R1"); expect_at(c, 3, 1'b1, "R1");
        expect_at(d + L + 1, 0, 1'b0, "R2");
        expect_at(d + L + 1, 2, 1'b0, "R2");
        expect_at(d + L + 2, 0, 1'b1, "R2");
        expect_at(d + L + 2, 2, 1'b1, "R2");

        wait_to(c);
        areset_req = 1'b1;
        wait_to(d);
        areset_req = 1'b0;

        wait_to(d + L + 5);
        @(negedge clk);
        foreach (sb[i]) begin
            errors++;
            $display("FAIL %s %s never sampled: actual - expected %b",
                     sb[i].req, sname(sb[i].sig), sb[i].val);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule